// File: doc/BRIEF.md
# Chip-Select Memory Timing Controller

This block runs one access at a time to an asynchronous memory or peripheral on a local bus where address and data share the same 32 lines. A requester presents an address, a direction, write data with byte enables, and the timing attributes of the bank: chip-select setup after the address, a wait-state count, an early write-strobe bit, a relaxed-timing bit and an extended read hold bit. The block then drives the address-latch strobe, chip select, output enable, byte write enables and the shared bus. It returns a one-cycle acknowledge and, for reads, the captured data.

The block is clocked at four ticks per bus cycle, so every strobe edge lands on a quarter-bus-cycle boundary. Each access begins with one bus cycle of address. During that cycle the latch strobe is high for the first half and the address is on the bus. A control phase follows, in which either the output enable or the write enables are low. It lasts one bus cycle plus the wait states. Relaxed timing stretches the access in four ways: it inserts a bus cycle before the control phase, doubles the wait states, lengthens the read hold, and pulls write strobes and chip select back by a full bus cycle.

In the text below, a tick is one internal clock cycle. Tick 0 is the first cycle after the request is taken. C is the first tick of the control phase and E is the first tick after it.

Top module: `csmem_ctrl`

## Requirements
- R1: After reset the block is idle. In that state `req_ready`=1, `ale`=0, `cs_n`=1, `oe_n`=1, `we_n`=4'hF and `ack`=0.
- R2: `ale` is high on ticks 0 and 1 only, and never while `oe_n` or any `we_n` is low. The request address is on `bus_ad` from tick 0 through tick C-1.
- R3: `cs_n` goes low at tick 0 when setup is 2'b00, at tick 1 when setup is 2'b01 or 2'b10, and at tick 2 when setup is 2'b11.
- R4: The control phase lasts 4*(1+W) ticks, so E = C + 4*(1+W). W is the 4-bit wait count, or twice that count when relaxed is set. Output enable (reads) or write enables (writes) go low at tick C.
- R5: C is 8 when relaxed is set and setup is not 2'b00. Otherwise C is 4.
- R6: On writes with the early-strobe bit set, the write enables rise one tick earlier than at E.
- R7: On relaxed writes, the write enables rise four more ticks earlier. Even so, they stay low at least through tick C.
- R8: On relaxed writes with setup not 2'b00, `cs_n` rises at E-4, but no earlier than tick C+1. In every other case `cs_n` rises at E. A write enable is never low while `cs_n` is high.
- R9: `oe_n` is low only on reads, on ticks C through E-1, and the block does not drive `bus_ad` while it is low. Write data is driven on ticks C through E-1. Read data on `bus_ad` at tick E-1 appears on `rsp_rdata` from tick E on.
- R10: `ack` is high for exactly one tick per access, at tick E-1.
- R11: A read with extended hold stays busy for an extra 4 ticks, or 16 ticks when relaxed is set, after E. Writes and other reads end at E. `req_ready` returns on the tick after the last busy tick.
- R12: On a write, only the lanes of `we_n` whose byte enable bit is 1 go low. Bit i of `we_n` corresponds to bit i of `req_be`.
- R13: While the block is busy, `req_valid` and the request inputs have no effect. Every access follows the request that was present when `req_ready` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, four ticks per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_setup | input | 2 | Chip-select setup code after address |
| req_waits | input | 4 | Wait-state count in bus cycles |
| req_early | input | 1 | Raise the write enables one tick early |
| req_relax | input | 1 | Relaxed timing |
| req_xhold | input | 1 | Extended read hold |
| req_ready | output | 1 | Idle; a request can be taken |
| ack | output | 1 | One-tick transfer acknowledge |
| rsp_rdata | output | 32 | Last captured read data |
| ale | output | 1 | Address-latch strobe, active high |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 4 | Byte write enables, active low |
| bus_ad | inout | 32 | Shared address/data bus |

## Verification
The assertions take it for granted that the external device drives `bus_ad` only while `oe_n` is low. They also take it that nothing else drives chip select or the strobes. The sequencer's hold check assumes that a request cannot change an access that is already running, whatever `req_valid` does. The bench's memory model drives the bus only under output enable, from an address it latches during `ale`. While an access is running, the stimulus puts junk requests on the inputs on purpose, to exercise the hold check.

// File: rtl/csmem_pkg.sv
// Shared constants and types for the chip-select memory timing controller.
// Assumes a fixed ratio of four internal ticks per bus cycle.
package csmem_pkg;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int WAIT_W = 4;
    localparam int TICKS  = 4;
    localparam int QTR    = TICKS / 4;
    localparam int MAXT   = TICKS * (2 * (1 << WAIT_W) + 5);
    localparam int TW     = $clog2(MAXT + 1);

    typedef struct packed {
        logic              write;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  be;
        logic [1:0]        setup;
        logic [WAIT_W-1:0] waits;
        logic              early;
        logic              relax;
        logic              xhold;
    } req_t;

    typedef struct packed {
        logic [TW-1:0] cs_on;
        logic [TW-1:0] ctl_start;
        logic [TW-1:0] ctl_end;
        logic [TW-1:0] we_end;
        logic [TW-1:0] cs_end;
        logic [TW-1:0] total;
    } tim_t;
endpackage

// File: rtl/csmem_timing.sv
// Converts the latched request attributes into tick boundaries of the access.
// Purely combinational; the boundaries are valid while the request is held.
module csmem_timing
    import csmem_pkg::*;
(
    input  req_t req,
    output tim_t tim
);
    localparam logic [TW-1:0] T_BUS  = TW'(TICKS);
    localparam logic [TW-1:0] T_QTR  = TW'(QTR);
    localparam logic [TW-1:0] T_HALF = TW'(2 * QTR);
    localparam logic [TW-1:0] T_LONG = TW'(4 * TICKS);

    logic          relax_gap;
    logic [TW-1:0] waits;
    logic [TW-1:0] early;
    logic [TW-1:0] hold;
    logic [TW-1:0] we_cut;
    logic [TW-1:0] cs_cut;

    // Compute every phase boundary, in ticks, from the attributes.
    always_comb begin
        relax_gap = req.relax && (req.setup != 2'b00);
        case (req.setup)
            2'b00:   tim.cs_on = '0;
            2'b11:   tim.cs_on = T_HALF;
            default: tim.cs_on = T_QTR;
        endcase
        tim.ctl_start = T_BUS + (relax_gap ? T_BUS : '0);
        waits         = req.relax ? (TW'(req.waits) << 1) : TW'(req.waits);
        tim.ctl_end   = tim.ctl_start + T_BUS * (waits + TW'(1));
        early         = (req.relax ? T_BUS : '0) + (req.early ? T_QTR : '0);
        we_cut        = tim.ctl_end - early;
        tim.we_end    = (we_cut > tim.ctl_start) ? we_cut : tim.ctl_start + TW'(1);
        cs_cut        = tim.ctl_end - T_BUS;
        if (req.write && relax_gap)
            tim.cs_end = (cs_cut > tim.ctl_start) ? cs_cut : tim.ctl_start + TW'(1);
        else
            tim.cs_end = tim.ctl_end;
        if (!req.write && req.xhold)
            hold = req.relax ? T_LONG : T_BUS;
        else
            hold = '0;
        tim.total = tim.ctl_end + hold;
    end
endmodule

// File: rtl/csmem_seq.sv
// Access sequencer: takes a request when idle, holds it, and counts ticks.
// Also captures read data on the acknowledge tick.
module csmem_seq
    import csmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  req_t              req_in,
    input  logic [TW-1:0]     total,
    input  logic              ack,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic [TW-1:0]     tick,
    output req_t              req_q,
    output logic [DATA_W-1:0] rdata
);
    logic last_tick;
    assign last_tick = (tick == total - TW'(1));

    // Take, hold and retire one access; tick counts from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            tick  <= '0;
            req_q <= '0;
        end else if (!busy) begin
            tick <= '0;
            if (req_valid) begin
                busy  <= 1'b1;
                req_q <= req_in;
            end
        end else if (last_tick) begin
            busy <= 1'b0;
            tick <= '0;
        end else begin
            tick <= tick + TW'(1);
        end
    end

    // Capture the bus at the read acknowledge tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (ack && !req_q.write)
            rdata <= bus_in;
    end

    p_tick_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tick < total));
    p_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);
    p_hold_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_tick) |=> (busy && $stable(req_q)));
endmodule

// File: rtl/csmem_strobes.sv
// Decodes the tick count against the boundaries into bus strobes and the
// drive enable of the shared bus. Assumes the request is held while busy.
module csmem_strobes
    import csmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [TW-1:0]     tick,
    input  req_t              req_q,
    input  tim_t              tim,
    output logic              ale,
    output logic              cs_n,
    output logic              oe_n,
    output logic [BYTES-1:0]  we_n,
    output logic              ack,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out
);
    localparam logic [TW-1:0] ALE_END = TW'(2 * QTR);

    logic in_ctl;
    logic we_win;

    // Phase windows and single strobes.
    always_comb begin
        in_ctl = busy && (tick >= tim.ctl_start) && (tick < tim.ctl_end);
        we_win = busy && req_q.write && (tick >= tim.ctl_start) && (tick < tim.we_end);
        ale    = busy && (tick < ALE_END);
        cs_n   = !(busy && (tick >= tim.cs_on) && (tick < tim.cs_end));
        oe_n   = !(in_ctl && !req_q.write);
        ack    = busy && (tick == tim.ctl_end - TW'(1));
        ad_oe  = busy && ((tick < tim.ctl_start) || (in_ctl && req_q.write));
        ad_out = (tick < tim.ctl_start) ? req_q.addr : req_q.wdata;
    end

    // One write-enable lane per byte, gated by its enable bit.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign we_n[i] = !(we_win && req_q.be[i]);
    end

    p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !(&we_n)));
    p_we_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(&we_n) |-> !cs_n);
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (oe_n && (&we_n)));
    p_read_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_oe);
endmodule

// File: rtl/csmem_ctrl.sv
// Top of the chip-select memory timing controller: one access at a time on a
// multiplexed address/data bus. Assumes the device drives the bus only while
// output enable is low.
module csmem_ctrl
    import csmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BYTES-1:0]  req_be,
    input  logic [1:0]        req_setup,
    input  logic [WAIT_W-1:0] req_waits,
    input  logic              req_early,
    input  logic              req_relax,
    input  logic              req_xhold,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ale,
    output logic              cs_n,
    output logic              oe_n,
    output logic [BYTES-1:0]  we_n,
    inout  wire  [DATA_W-1:0] bus_ad
);
    req_t              req_in;
    req_t              req_q;
    tim_t              tim;
    logic              busy;
    logic [TW-1:0]     tick;
    logic              ad_oe;
    logic [DATA_W-1:0] ad_out;

    // Gather the request fields.
    always_comb begin
        req_in.write = req_write;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
        req_in.be    = req_be;
        req_in.setup = req_setup;
        req_in.waits = req_waits;
        req_in.early = req_early;
        req_in.relax = req_relax;
        req_in.xhold = req_xhold;
    end

    csmem_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(req_in),
        .total(tim.total), .ack(ack), .bus_in(bus_ad),
        .busy(busy), .tick(tick), .req_q(req_q), .rdata(rsp_rdata)
    );

    csmem_timing u_tim (.req(req_q), .tim(tim));

    csmem_strobes u_stb (
        .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick), .req_q(req_q),
        .tim(tim), .ale(ale), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .ack(ack), .ad_oe(ad_oe), .ad_out(ad_out)
    );

    assign req_ready = !busy;
    assign bus_ad    = ad_oe ? ad_out : 'z;
endmodule

// File: tb/csmem_ctrl_test.sv
`timescale 1ns/1ps
module csmem_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0, req_waits = '0;
    logic [1:0]  req_setup = '0;
    logic        req_early = 1'b0, req_relax = 1'b0, req_xhold = 1'b0;
    logic        req_ready, ack, ale, cs_n, oe_n;
    logic [31:0] rsp_rdata;
    logic [3:0]  we_n;
    wire  [31:0] ad;
    logic [31:0] lat_addr = '0;

    int checks = 0, errors = 0, issued = 0, observed = 0;

    typedef struct {
        bit wr; int c, e, cs_first, cs_last, oe_first, oe_last, we_first, we_last, ack_t, len;
        logic [31:0] addr, wdata, rdata; logic [3:0] mask;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    csmem_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_setup(req_setup), .req_waits(req_waits), .req_early(req_early),
        .req_relax(req_relax), .req_xhold(req_xhold), .req_ready(req_ready),
        .ack(ack), .rsp_rdata(rsp_rdata), .ale(ale), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .bus_ad(ad)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A5A_0000;
    endfunction

    // Memory model: drives the bus only under output enable.
    assign ad = !oe_n ? memf(lat_addr) : 'z;
    always @(negedge clk) if (ale) lat_addr <= ad;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input logic [1:0] su, input int ws,
                         input bit er, input bit rl, input bit xh, input bit noise);
        exp_t e;
        int w, early;
        e.wr = wr; e.addr = a; e.wdata = d;
        e.c = 4 + ((rl && su != 0) ? 4 : 0);
        w = rl ? 2 * ws : ws;
        e.e = e.c + 4 * (1 + w);
        e.cs_first = (su == 0) ? 0 : ((su == 3) ? 2 : 1);
        e.ack_t = e.e - 1;
        e.rdata = memf(a);
        if (wr) begin
            early = (rl ? 4 : 0) + (er ? 1 : 0);
            e.we_first = e.c; e.we_last = imax(e.c, e.e - 1 - early);
            e.cs_last = (rl && su != 0) ? imax(e.c, e.e - 5) : e.e - 1;
            e.oe_first = -1; e.oe_last = -1; e.mask = be; e.len = e.e;
        end else begin
            e.oe_first = e.c; e.oe_last = e.e - 1; e.cs_last = e.e - 1;
            e.we_first = -1; e.we_last = -1; e.mask = 4'h0;
            e.len = e.e + (xh ? (rl ? 16 : 4) : 0);
        end
        q.push_back(e);
        issued++;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        req_setup = su; req_waits = 4'(ws); req_early = er; req_relax = rl; req_xhold = xh;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_setup = 2'b11;
            req_waits = 4'hF; req_relax = 1'b1; req_xhold = 1'b1; req_be = ~be;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: measures each access and compares it with the queue head.
    bit in_tx = 0, grab = 0;
    int t, ale_cnt, ale_last, cs_first, cs_last, oe_first, oe_last, we_first, we_last;
    int ack_t, ack_cnt;
    logic [3:0] mask;
    logic [31:0] rd;
    logic [31:0] ad_log [0:255];

    always @(negedge clk) begin
        if (rst_n) begin
            if (grab && (req_ready || !ack)) begin rd = rsp_rdata; grab = 0; end
            if (!req_ready) begin
                if (!in_tx) begin
                    in_tx = 1; t = 0; ale_cnt = 0; ale_last = -1; cs_first = -1; cs_last = -1;
                    oe_first = -1; oe_last = -1; we_first = -1; we_last = -1;
                    ack_t = -1; ack_cnt = 0; mask = 4'h0; rd = '0;
                end else t++;
                ad_log[t] = ad;
                if (ale) begin ale_cnt++; ale_last = t; end
                if (!cs_n) begin if (cs_first < 0) cs_first = t; cs_last = t; end
                if (!oe_n) begin if (oe_first < 0) oe_first = t; oe_last = t; end
                if (we_n != 4'hF) begin if (we_first < 0) we_first = t; we_last = t; end
                mask = mask | ~we_n;
                if (ack) begin ack_cnt++; ack_t = t; grab = 1; end
            end else if (in_tx) begin
                exp_t e;
                in_tx = 0; observed++;
                e = q.pop_front();
                chk("R2 ale ticks", ale_cnt, 2);
                chk("R2 ale last", ale_last, 1);
                chk("R2 address at tick 0", int'(ad_log[0] == e.addr), 1);
                chk("R2 address at tick C-1", int'(ad_log[e.c - 1] == e.addr), 1);
                chk("R3 cs first", cs_first, e.cs_first);
                chk("R4 R5 ctl start oe", oe_first, e.oe_first);
                chk("R4 R5 ctl start we", we_first, e.we_first);
                chk("R4 oe last", oe_last, e.oe_last);
                chk("R6 R7 we last", we_last, e.we_last);
                chk("R8 cs last", cs_last, e.cs_last);
                chk("R10 ack tick", ack_t, e.ack_t);
                chk("R10 ack count", ack_cnt, 1);
                chk("R11 busy length", t + 1, e.len);
                chk("R12 we lanes", int'(mask), int'(e.mask));
                if (e.wr) begin
                    chk("R9 wdata at C", int'(ad_log[e.c] == e.wdata), 1);
                    chk("R9 wdata at E-1", int'(ad_log[e.e - 1] == e.wdata), 1);
                end else begin
                    chk("R9 read data", int'(rd == e.rdata), 1);
                    if (rd != e.rdata) $display("FAIL R9 rdata: actual %h expected %h", rd, e.rdata);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 cs_n", int'(cs_n), 1);
        chk("R1 oe_n", int'(oe_n), 1);
        chk("R1 we_n", int'(we_n), 15);
        chk("R1 ale", int'(ale), 0);
        chk("R1 ack", int'(ack), 0);
        issue(0, 32'h0000_1234, 0, 4'h0, 2'b00, 0, 0, 0, 0, 0);
        issue(1, 32'h0000_2000, 32'hCAFE_F00D, 4'hF, 2'b00, 0, 1, 0, 0, 0);
        issue(0, 32'h0000_3456, 0, 4'h0, 2'b10, 2, 0, 0, 1, 0);
        issue(1, 32'h0000_4000, 32'h1122_3344, 4'h5, 2'b11, 3, 0, 0, 0, 0);
        issue(0, 32'h0000_5678, 0, 4'h0, 2'b11, 1, 0, 1, 0, 0);
        issue(0, 32'h0000_6ABC, 0, 4'h0, 2'b10, 1, 0, 1, 1, 0);
        issue(1, 32'h0000_7000, 32'hA5A5_5A5A, 4'h3, 2'b10, 1, 0, 1, 0, 0);
        issue(1, 32'h0000_8000, 32'h0F0F_F0F0, 4'hC, 2'b00, 2, 1, 1, 0, 0);
        issue(1, 32'h0000_9000, 32'hDEAD_BEEF, 4'hF, 2'b11, 0, 1, 1, 0, 0);
        issue(0, 32'h0000_ABCD, 0, 4'h0, 2'b01, 15, 0, 1, 0, 0);
        issue(1, 32'h0000_B000, 32'h8765_4321, 4'h8, 2'b00, 15, 0, 0, 0, 0);
        issue(1, 32'h0000_C000, 32'h1357_9BDF, 4'h2, 2'b01, 0, 1, 0, 0, 0);
        issue(0, 32'h0000_D111, 0, 4'h0, 2'b00, 1, 0, 0, 0, 1);
        issue(0, 32'h0000_E222, 0, 4'h0, 2'b00, 0, 0, 0, 1, 0);
        issue(1, 32'h0000_F000, 32'h2468_ACE0, 4'h1, 2'b10, 0, 0, 0, 0, 1);
        do @(negedge clk); while (q.size() != 0 || in_tx);
        repeat (4) @(negedge clk);
        chk("R13 access count", observed, issued);
        chk("R1 idle after run", int'(req_ready && cs_n && oe_n), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule